// File: doc/BRIEF.md
# ZVS Full-Bridge PWM Timing Generator

This block produces the four gate commands for a full bridge that uses zero-voltage switching. A cycle counter builds the time base. Each period has a ramp interval followed by a deadtime interval. Two periods make one switching cycle, and each period serves one bridge diagonal. Diagonal A pairs upper-left with lower-right, and diagonal B pairs upper-right with lower-left.

The upper pair runs at a fixed 50% duty and ignores the duty command. It hands over to the next diagonal inside the deadtime, a programmable resonant-delay time before the next lower switch turns on. Only the lower pair is modulated. A lower pulse starts at the first ramp cycle and ends on its trailing edge. It ends when the duty count runs out, or earlier when the overcurrent input rises after a leading-edge blanking window. Pulse steering keeps successive lower pulses alternating between left and right. A fault input forces all outputs low and restarts the time base. The ramp length, deadtime length, resonant-delay code and duty command are captured once, at the start of each period.

Top module: `zvs_bridge_pwm`

## Requirements
- R1: A period is max(ramp_len,1) ramp cycles followed by max(dead_len,1) deadtime cycles. Ramp length, deadtime length, delay code and duty command are captured only on the edge that starts a period, so a change during a period takes effect in the next one.
- R2: Outside fault and the idle cycle, exactly one of out_ul and out_ur is high. The first period after reset or fault is diagonal A, with out_ul high during its ramp, and the diagonal alternates every period.
- R3: In each period, the upper outputs swap to the next diagonal for the last rdel deadtime cycles, where rdel = floor(D * min(rdel_code,16) / 16) and D is the deadtime length. A code of 0 swaps at the period boundary, and a code of 16 or more swaps for the whole deadtime.
- R4: A diagonal-A period drives out_lr and a diagonal-B period drives out_ll. The output is high from the first ramp cycle for min(duty_cmd, ramp length) cycles, and never during the deadtime.
- R5: A duty command of 0 keeps both lower outputs low while the upper outputs keep alternating.
- R6: During the first BLANK_CYC (3) ramp cycles, oc_flag has no effect. From then on, oc_flag high ends the active lower pulse in the same cycle, and the pulse stays low for the rest of the period even after oc_flag falls.
- R7: An overcurrent is not a fault. The next period pulses at its full commanded width.
- R8: A lower pulse is suppressed when the most recent lower pulse was on the same output. After reset or fault, out_lr is allowed first.
- R9: While fault_flag is high, all four outputs are low in the same cycle. After fault_flag falls, the outputs stay low for one idle cycle, and then a new diagonal-A period starts.
- R10: All outputs are low during reset and in the cycle after reset is released.
- R11: out_lr is high only while out_ul is high, and out_ll only while out_ur is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ramp_len | input | CNT_W | Ramp interval length in cycles (0 treated as 1) |
| dead_len | input | CNT_W | Deadtime interval length in cycles (0 treated as 1) |
| rdel_code | input | FRAC_W+1 | Resonant-delay fraction, in sixteenths of the deadtime |
| duty_cmd | input | CNT_W | Lower pulse width command in cycles |
| oc_flag | input | 1 | Overcurrent indication |
| fault_flag | input | 1 | Undervoltage or over-temperature fault |
| out_ul | output | 1 | Upper-left gate command |
| out_ur | output | 1 | Upper-right gate command |
| out_ll | output | 1 | Lower-left gate command |
| out_lr | output | 1 | Lower-right gate command |

## Verification
The overcurrent cut and the end of leading-edge blanking meet when oc_flag rises on the last blanked cycle or the first unblanked one. Overcurrent pulses are placed on both sides of that boundary. Each is judged by the exact cycle in which the lower output falls, and by whether it stays low afterwards. The steering decision and the period boundary also fall in the same cycle: a zero-duty period is wedged between two pulsing periods, and the bench checks that the following same-side pulse is suppressed while the upper outputs still alternate.

// File: rtl/zvs_pkg.sv
package zvs_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_RAMP = 2'd1,
    PH_DEAD = 2'd2
  } phase_e;

  localparam logic SIDE_A = 1'b0;
  localparam logic SIDE_B = 1'b1;
endpackage

// File: rtl/zvs_timebase.sv
module zvs_timebase
  import zvs_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int FRAC_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fault,
  input  logic [CNT_W-1:0]  ramp_len,
  input  logic [CNT_W-1:0]  dead_len,
  input  logic [FRAC_W:0]   rdel_code,
  output phase_e            phase,
  output logic [CNT_W-1:0]  cnt,
  output logic [CNT_W-1:0]  dead_l,
  output logic [CNT_W-1:0]  rdel_l,
  output logic              side,
  output logic              wrap,
  output logic              load
);
  localparam int PROD_W = CNT_W + FRAC_W + 1;
  localparam logic [FRAC_W:0] FULL = {1'b1, {FRAC_W{1'b0}}};

  phase_e            ph_n;
  logic [CNT_W-1:0]  cnt_n;
  logic              side_n;
  logic [CNT_W-1:0]  ramp_l;
  logic [CNT_W-1:0]  ramp_in, dead_in, rdel_in;
  logic [FRAC_W:0]   code_c;
  logic [PROD_W-1:0] prod;

  // Operand conditioning for the captured parameters
  always_comb begin
    ramp_in = (ramp_len == '0) ? CNT_W'(1) : ramp_len;
    dead_in = (dead_len == '0) ? CNT_W'(1) : dead_len;
    code_c  = (rdel_code > FULL) ? FULL : rdel_code;
    prod    = {{(FRAC_W+1){1'b0}}, dead_in} * {{CNT_W{1'b0}}, code_c};
    rdel_in = CNT_W'(prod >> FRAC_W);
  end

  assign wrap = (phase == PH_DEAD) && (cnt == dead_l - 1'b1);
  assign load = !fault && ((phase == PH_IDLE) || wrap);

  always_comb begin
    ph_n   = phase;
    cnt_n  = cnt;
    side_n = side;
    if (fault) begin
      ph_n   = PH_IDLE;
      cnt_n  = '0;
      side_n = SIDE_A;
    end else begin
      case (phase)
        PH_IDLE: begin
          ph_n  = PH_RAMP;
          cnt_n = '0;
        end
        PH_RAMP: begin
          if (cnt == ramp_l - 1'b1) begin
            ph_n  = PH_DEAD;
            cnt_n = '0;
          end else begin
            cnt_n = cnt + 1'b1;
          end
        end
        PH_DEAD: begin
          if (wrap) begin
            ph_n   = PH_RAMP;
            cnt_n  = '0;
            side_n = ~side;
          end else begin
            cnt_n = cnt + 1'b1;
          end
        end
        default: begin
          ph_n  = PH_IDLE;
          cnt_n = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      cnt   <= '0;
      side  <= SIDE_A;
    end else begin
      phase <= ph_n;
      cnt   <= cnt_n;
      side  <= side_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ramp_l <= CNT_W'(1);
      dead_l <= CNT_W'(1);
      rdel_l <= '0;
    end else if (load) begin
      ramp_l <= ramp_in;
      dead_l <= dead_in;
      rdel_l <= rdel_in;
    end
  end

  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    ((phase == PH_RAMP) |-> (cnt < ramp_l)) and ((phase == PH_DEAD) |-> (cnt < dead_l))); // R1
  AST_RDEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    rdel_l <= dead_l); // R3
endmodule

// File: rtl/zvs_lower_mod.sv
module zvs_lower_mod
  import zvs_pkg::*;
#(
  parameter int CNT_W     = 8,
  parameter int BLANK_CYC = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fault,
  input  phase_e           phase,
  input  logic [CNT_W-1:0] cnt,
  input  logic             side,
  input  logic             load,
  input  logic [CNT_W-1:0] duty_in,
  input  logic             oc,
  output logic [1:0]       lower
);
  localparam logic [CNT_W-1:0] BLANK_V = CNT_W'(BLANK_CYC);

  logic [CNT_W-1:0] duty_l, duty_n;
  logic             cut_q, cut_n;
  logic             seen_q, seen_n;
  logic             last_q, last_n;
  logic             allowed, base, kill, pulse;

  assign allowed = (side != last_q);
  assign base    = (phase == PH_RAMP) && (cnt < duty_l) && allowed;
  assign kill    = oc && (cnt >= BLANK_V);
  assign pulse   = base && !cut_q && !kill;

  always_comb begin
    duty_n = duty_l;
    cut_n  = cut_q;
    seen_n = seen_q;
    last_n = last_q;
    if (fault) begin
      cut_n  = 1'b0;
      seen_n = 1'b0;
      last_n = SIDE_B;
    end else if (load) begin
      duty_n = duty_in;
      cut_n  = 1'b0;
      seen_n = 1'b0;
      last_n = seen_q ? side : last_q;
    end else begin
      if (base && kill) cut_n = 1'b1;
      if (pulse)        seen_n = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      duty_l <= '0;
      cut_q  <= 1'b0;
      seen_q <= 1'b0;
      last_q <= SIDE_B;
    end else begin
      duty_l <= duty_n;
      cut_q  <= cut_n;
      seen_q <= seen_n;
      last_q <= last_n;
    end
  end

  // lower[0] serves diagonal A (lower-right), lower[1] diagonal B (lower-left)
  for (genvar s = 0; s < 2; s++) begin : g_side
    localparam logic SV = 1'(s);
    assign lower[s] = pulse && (side == SV);
  end

  AST_NO_PULSE_IN_DEAD: assert property (@(posedge clk) disable iff (!rst_n)
    (|lower) |-> (phase == PH_RAMP)); // R4
  AST_NO_REARM: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(|lower) |-> (cnt == '0)); // R6
endmodule

// File: rtl/zvs_upper_drv.sv
module zvs_upper_drv
  import zvs_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  phase_e           phase,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] dead_l,
  input  logic [CNT_W-1:0] rdel_l,
  input  logic             side,
  output logic             ul,
  output logic             ur
);
  logic swap, cur, active;

  assign swap   = (phase == PH_DEAD) && (cnt >= dead_l - rdel_l);
  assign cur    = side ^ swap;
  assign active = (phase != PH_IDLE);
  assign ul     = active && (cur == SIDE_A);
  assign ur     = active && (cur == SIDE_B);
endmodule

// File: rtl/zvs_bridge_pwm.sv
module zvs_bridge_pwm
  import zvs_pkg::*;
#(
  parameter int CNT_W     = 8,
  parameter int FRAC_W    = 4,
  parameter int BLANK_CYC = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  ramp_len,
  input  logic [CNT_W-1:0]  dead_len,
  input  logic [FRAC_W:0]   rdel_code,
  input  logic [CNT_W-1:0]  duty_cmd,
  input  logic              oc_flag,
  input  logic              fault_flag,
  output logic              out_ul,
  output logic              out_ur,
  output logic              out_ll,
  output logic              out_lr
);
  phase_e           phase;
  logic [CNT_W-1:0] cnt, dead_l, rdel_l;
  logic             side, wrap, load;
  logic [1:0]       lower;
  logic             ul_i, ur_i;

  zvs_timebase #(.CNT_W(CNT_W), .FRAC_W(FRAC_W)) u_tb (
    .clk(clk), .rst_n(rst_n), .fault(fault_flag),
    .ramp_len(ramp_len), .dead_len(dead_len), .rdel_code(rdel_code),
    .phase(phase), .cnt(cnt), .dead_l(dead_l), .rdel_l(rdel_l),
    .side(side), .wrap(wrap), .load(load)
  );

  zvs_lower_mod #(.CNT_W(CNT_W), .BLANK_CYC(BLANK_CYC)) u_low (
    .clk(clk), .rst_n(rst_n), .fault(fault_flag),
    .phase(phase), .cnt(cnt), .side(side), .load(load),
    .duty_in(duty_cmd), .oc(oc_flag), .lower(lower)
  );

  zvs_upper_drv #(.CNT_W(CNT_W)) u_up (
    .phase(phase), .cnt(cnt), .dead_l(dead_l), .rdel_l(rdel_l),
    .side(side), .ul(ul_i), .ur(ur_i)
  );

  assign out_ul = ul_i && !fault_flag;
  assign out_ur = ur_i && !fault_flag;
  assign out_lr = lower[0] && !fault_flag;
  assign out_ll = lower[1] && !fault_flag;

  AST_UPPER_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (!fault_flag && (phase != PH_IDLE)) |-> (out_ul ^ out_ur)); // R2
  AST_DIAG_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    (out_lr |-> out_ul) and (out_ll |-> out_ur)); // R11
  AST_QUIET_AFTER_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fault_flag) |-> !(out_ul || out_ur || out_ll || out_lr)); // R9
  AST_WRAP_FLIPS_DIAG: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && !fault_flag) |=> (side != $past(side))); // R2
endmodule

// File: tb/tb_zvs_bridge_pwm.sv
module tb_zvs_bridge_pwm;
  localparam int CW = 8;
  localparam int FW = 4;
  localparam int BLANK = 3;

  // {ramp, dead, code, duty}
  localparam logic [28:0] VEC [0:5] = '{
    {8'd10, 8'd4, 5'd8,  8'd5},
    {8'd12, 8'd6, 5'd16, 8'd20},
    {8'd8,  8'd5, 5'd0,  8'd3},
    {8'd6,  8'd8, 5'd20, 8'd6},
    {8'd9,  8'd3, 5'd5,  8'd1},
    {8'd0,  8'd0, 5'd16, 8'd1}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [CW-1:0] ramp_len = 8'd10, dead_len = 8'd4, duty_cmd = 8'd5;
  logic [FW:0] rdel_code = 5'd8;
  logic oc_flag = 1'b0, fault_flag = 1'b0;
  logic out_ul, out_ur, out_ll, out_lr;

  int checks = 0;
  int fails = 0;
  bit exp_side = 1'b0;
  bit exp_last = 1'b1;

  always #2 clk = ~clk;

  zvs_bridge_pwm #(.CNT_W(CW), .FRAC_W(FW), .BLANK_CYC(BLANK)) dut (
    .clk(clk), .rst_n(rst_n), .ramp_len(ramp_len), .dead_len(dead_len),
    .rdel_code(rdel_code), .duty_cmd(duty_cmd), .oc_flag(oc_flag),
    .fault_flag(fault_flag), .out_ul(out_ul), .out_ur(out_ur),
    .out_ll(out_ll), .out_lr(out_lr)
  );

  wire [3:0] outs = {out_ul, out_ur, out_ll, out_lr};

  task automatic check(input bit ok, input string req, input string what,
                       input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %b expected %b (ul,ur,ll,lr)", req, what, act, exp);
    end
  endtask

  // Checks one whole period cycle by cycle against the requirement model.
  task automatic run_period(input string req, input int oc_a, input int oc_b, input int dnew);
    int r, d, c, rd, du, badi;
    bit allowed, cut, seen, bad, lo, up, base;
    logic [3:0] e, ba, be;
    r  = (ramp_len == 0) ? 1 : int'(ramp_len);
    d  = (dead_len == 0) ? 1 : int'(dead_len);
    c  = (rdel_code > 16) ? 16 : int'(rdel_code);
    rd = (d * c) / 16;
    du = int'(duty_cmd);
    allowed = (exp_side != exp_last);
    cut = 0; seen = 0; bad = 0; badi = 0; ba = '0; be = '0;
    for (int i = 0; i < r + d; i++) begin
      @(negedge clk);
      oc_flag = (i >= oc_a) && (i <= oc_b);
      if (i == 1 && dnew >= 0) duty_cmd = dnew[7:0];
      #1;
      base = allowed && (i < r) && (i < du);
      if (base && oc_flag && i >= BLANK) cut = 1;
      lo = base && !cut;
      if (lo) seen = 1;
      up = exp_side ^ ((i >= r) && ((i - r) >= (d - rd)));
      e = {!up, up, lo && exp_side, lo && !exp_side};
      if (outs !== e && !bad) begin
        bad = 1; ba = outs; be = e; badi = i;
      end
    end
    oc_flag = 1'b0;
    if (seen) exp_last = exp_side;
    exp_side = ~exp_side;
    check(!bad, req, $sformatf("period cycle %0d", badi), ba, be);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    fault_flag = 1'b0;
    oc_flag = 1'b0;
    repeat (3) @(negedge clk);
    #1 check(outs == 4'b0000, "R10", "outputs during reset", outs, 4'b0000);
    @(negedge clk);
    rst_n = 1'b1;
    #1 check(outs == 4'b0000, "R10", "idle cycle after release", outs, 4'b0000);
    exp_side = 1'b0;
    exp_last = 1'b1;
  endtask

  initial begin
    {ramp_len, dead_len, rdel_code, duty_cmd} = VEC[0];
    do_reset();

    // Vector table: each entry covers one A and one B period (R1 R2 R3 R4)
    for (int k = 0; k < 6; k++) begin
      {ramp_len, dead_len, rdel_code, duty_cmd} = VEC[k];
      run_period("R1 R2 R3 R4", -1, -1, -1);
      run_period("R1 R2 R3 R4", -1, -1, -1);
    end

    // R1: duty changed mid-period applies to the next period only
    ramp_len = 8'd10; dead_len = 8'd4; rdel_code = 5'd8; duty_cmd = 8'd3;
    run_period("R1", -1, -1, 9);
    run_period("R1", -1, -1, -1);

    // R5: zero duty, upper keeps alternating
    duty_cmd = 8'd0;
    run_period("R5", -1, -1, -1);
    run_period("R5", -1, -1, -1);

    // R8: pulse, skip, suppressed same-side pulse, other side pulses
    duty_cmd = 8'd4;
    run_period("R8", -1, -1, -1);
    duty_cmd = 8'd0;
    run_period("R8", -1, -1, -1);
    duty_cmd = 8'd4;
    run_period("R8", -1, -1, -1);
    run_period("R8", -1, -1, -1);
    run_period("R8", -1, -1, -1);

    // R6: overcurrent inside blanking ignored, then after blanking cuts
    duty_cmd = 8'd8;
    run_period("R6", 0, BLANK - 1, -1);
    run_period("R6", 5, 5, -1);
    run_period("R6", BLANK, BLANK, -1);
    // R7: next period at full width
    run_period("R7", -1, -1, -1);

    // R9: fault mid-period
    repeat (3) @(negedge clk);
    fault_flag = 1'b1;
    #1 check(outs == 4'b0000, "R9", "same cycle as fault", outs, 4'b0000);
    repeat (2) begin
      @(negedge clk);
      #1 check(outs == 4'b0000, "R9", "fault held", outs, 4'b0000);
    end
    @(negedge clk);
    fault_flag = 1'b0;
    #1 check(outs == 4'b0000, "R9", "idle cycle after fault", outs, 4'b0000);
    exp_side = 1'b0;
    exp_last = 1'b1;
    run_period("R9", -1, -1, -1);
    run_period("R9", -1, -1, -1);

    // R10: reset in the middle of operation
    repeat (5) @(negedge clk);
    do_reset();
    run_period("R10", -1, -1, -1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL R1 watchdog: actual still running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule